// File: doc/BRIEF.md
# Performance Level Request Controller

This block decides which performance level index a processor subsystem asks its voltage and clock scaling logic to use. Software programs one 32-bit control word over a simple write/read port. From that word and three live inputs (a software-requested level, a maximum-performance trigger and a PWM state bit) the block produces two registered 3-bit targets. One target goes to the voltage domain and one to the clock domain. It also drives a power request line. The highest level is 7 and the lowest is 0.

The boosted level that the trigger requests is programmable. Software can therefore keep an interrupt-driven boost below an overdrive level. A debug setting separates the two targets: the voltage target is pinned at the top level while the clock target keeps tracking the normal selection. An optional request/acknowledge exchange guards entry to and exit from the boosted mode. It is run by a four-state machine:
- `HS_IDLE`: no request.
- `HS_ASK`: request raised, waiting for the acknowledge.
- `HS_HELD`: boost granted.
- `HS_RELEASE`: request dropped, waiting for the acknowledge to fall.

Its transitions are:
- IDLE→ASK when the boost is wanted.
- ASK→HELD on the acknowledge.
- HELD→RELEASE when the boost is no longer wanted.
- RELEASE→IDLE once the acknowledge is low.
- Any state→IDLE while handshaking is off.

Top module: `perf_level_ctrl`

## Requirements
- R1: After reset the control word reads 0x000000E0, both targets are 7, and `pwr_req` and `hs_req` are 0.
- R2: The control word fields are: bit 0 global enable, bit 1 PWM mode, bit 2 boost override, bit 3 debug, bit 4 handshake enable, bits [7:5] boost level. A write on a clock edge with `reg_we` high is visible on `reg_rdata` after that edge.
- R3: Bits [31:8] always read as zero, and writing ones to them has no effect.
- R4: While the global enable is 0, both targets are 7 and `pwr_req` is 0, whatever the other bits and inputs are.
- R5: With enable and override set, a high trigger selects the programmed boost level for both targets. This takes precedence over PWM mode and over the software level.
- R6: A boost level below 7 (for example 3) is honoured exactly. The trigger then never yields 7 through the boost path.
- R7: With enable and debug set, the voltage target is 7, while the clock target shows the level that would otherwise be selected.
- R8: With enable and PWM mode set, `pwr_req` is 1. Each target is 7 when `pwm_state` is 1 and 0 when it is 0, unless the boost is active.
- R9: With enable set and no boost or PWM mode, both targets follow `sw_lvl`.
- R10: With handshaking disabled, `hs_req` stays 0, `hs_ack` has no effect, and the boost follows override AND trigger directly.
- R11: With handshaking enabled, `hs_req` rises one cycle after the trigger is sampled high. The targets change to the boost level only one cycle after the acknowledge has been sampled high.
- R12: On exit, `hs_req` falls one cycle after the trigger is sampled low. The targets hold the boost level until the acknowledge is sampled low, and revert one cycle later.
- R13: Targets and `pwr_req` are registered: they change one clock after the inputs or control word that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| sw_lvl | input | 3 | Software-requested level |
| boost_trig | input | 1 | Maximum-performance trigger |
| pwm_state | input | 1 | PWM phase: 1 selects top level, 0 bottom |
| hs_ack | input | 1 | Handshake acknowledge |
| hs_req | output | 1 | Handshake request |
| vdom_idx | output | 3 | Voltage-domain target level |
| cdom_idx | output | 3 | Clock-domain target level |
| pwr_req | output | 1 | Power request for PWM mode |

## Verification
The bench targets the precedence corners: override against PWM, debug splitting the targets, and a disabled block with other bits set. A wrong priority would show PWM or software levels during a boost, or a non-7 level while disabled. The handshake sequence checks that the boost level appears neither before the acknowledge nor after it drops. An ungated machine would switch early or revert while the acknowledge is still high. Reserved write data and a toggling acknowledge with handshaking off check for state that should not be reachable.

// File: rtl/plc_pkg.sv
package plc_pkg;
    localparam int LVL_W = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_TOP    = {LVL_W{1'b1}};
    localparam lvl_t LVL_BOTTOM = {LVL_W{1'b0}};

    // Field order is the software-visible bit layout, MSB first.
    typedef struct packed {
        lvl_t boost_lvl;
        logic sync_en;
        logic dbg_en;
        logic ovr_en;
        logic pwm_en;
        logic glob_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_RST = '{
        boost_lvl: LVL_TOP,
        sync_en:   1'b0,
        dbg_en:    1'b0,
        ovr_en:    1'b0,
        pwm_en:    1'b0,
        glob_en:   1'b0
    };

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_ASK,
        HS_HELD,
        HS_RELEASE
    } hs_state_e;
endpackage

// File: rtl/plc_ctrl_reg.sv
module plc_ctrl_reg
    import plc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] rd_data
);
    localparam int RSV_W = DATA_W - CTRL_W;

    ctrl_t ctrl_q;
    logic  unused_rsv_bits;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (wr_en) begin
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    assign unused_rsv_bits = ^wr_data[DATA_W-1:CTRL_W];
    assign ctrl            = ctrl_q;
    assign rd_data         = {{RSV_W{1'b0}}, ctrl_q};
endmodule

// File: rtl/plc_hs_fsm.sv
module plc_hs_fsm
    import plc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_en,
    input  logic boost_want,
    input  logic ack,
    output logic req,
    output logic boost_active
);
    hs_state_e state_q;
    hs_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!sync_en) begin
            state_d = HS_IDLE;
        end else begin
            unique case (state_q)
                HS_IDLE:    if (boost_want) state_d = HS_ASK;
                HS_ASK:     if (ack)        state_d = HS_HELD;
                HS_HELD:    if (!boost_want) state_d = HS_RELEASE;
                HS_RELEASE: if (!ack)       state_d = HS_IDLE;
            endcase
        end
    end

    always_comb begin
        req          = 1'b0;
        boost_active = boost_want;
        if (sync_en) begin
            unique case (state_q)
                HS_IDLE: begin
                    req          = 1'b0;
                    boost_active = 1'b0;
                end
                HS_ASK: begin
                    req          = 1'b1;
                    boost_active = 1'b0;
                end
                HS_HELD: begin
                    req          = 1'b1;
                    boost_active = 1'b1;
                end
                HS_RELEASE: begin
                    req          = 1'b0;
                    boost_active = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/plc_level_sel.sv
module plc_level_sel
    import plc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    input  lvl_t  sw_lvl,
    input  logic  pwm_state,
    input  logic  boost_active,
    output lvl_t  vdom_idx,
    output lvl_t  cdom_idx,
    output logic  pwr_req
);
    lvl_t sel_lvl;
    lvl_t vsel_lvl;
    lvl_t vdom_q;
    lvl_t cdom_q;
    logic pwr_q;

    always_comb begin
        if (!ctrl.glob_en) begin
            sel_lvl = LVL_TOP;
        end else if (boost_active) begin
            sel_lvl = ctrl.boost_lvl;
        end else if (ctrl.pwm_en) begin
            sel_lvl = pwm_state ? LVL_TOP : LVL_BOTTOM;
        end else begin
            sel_lvl = sw_lvl;
        end
        vsel_lvl = (ctrl.glob_en && ctrl.dbg_en) ? LVL_TOP : sel_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vdom_q <= LVL_TOP;
            cdom_q <= LVL_TOP;
            pwr_q  <= 1'b0;
        end else begin
            vdom_q <= vsel_lvl;
            cdom_q <= sel_lvl;
            pwr_q  <= ctrl.glob_en && ctrl.pwm_en;
        end
    end

    assign vdom_idx = vdom_q;
    assign cdom_idx = cdom_q;
    assign pwr_req  = pwr_q;
endmodule

// File: rtl/perf_level_ctrl.sv
module perf_level_ctrl
    import plc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [LVL_W-1:0]  sw_lvl,
    input  logic              boost_trig,
    input  logic              pwm_state,
    input  logic              hs_ack,
    output logic              hs_req,
    output logic [LVL_W-1:0]  vdom_idx,
    output logic [LVL_W-1:0]  cdom_idx,
    output logic              pwr_req
);
    ctrl_t ctrl;
    logic  boost_active;

    plc_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_data (reg_wdata),
        .ctrl    (ctrl),
        .rd_data (reg_rdata)
    );

    plc_hs_fsm u_hs (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_en      (ctrl.sync_en),
        .boost_want   (ctrl.ovr_en && boost_trig),
        .ack          (hs_ack),
        .req          (hs_req),
        .boost_active (boost_active)
    );

    plc_level_sel u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl         (ctrl),
        .sw_lvl       (sw_lvl),
        .pwm_state    (pwm_state),
        .boost_active (boost_active),
        .vdom_idx     (vdom_idx),
        .cdom_idx     (cdom_idx),
        .pwr_req      (pwr_req)
    );
endmodule

// File: rtl/plc_check.sv
module plc_check
    import plc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              hs_req,
    input logic [LVL_W-1:0]  vdom_idx,
    input logic [LVL_W-1:0]  cdom_idx,
    input logic              pwr_req
);
    a_r3_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:CTRL_W] == '0);

    a_r4_off_top: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[0] |=> (vdom_idx == LVL_TOP && cdom_idx == LVL_TOP && !pwr_req));

    a_r7_dbg_vtop: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] && reg_rdata[3]) |=> vdom_idx == LVL_TOP);

    a_r7_nodbg_same: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[3] |=> vdom_idx == cdom_idx);

    a_r8_pwr_on: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] && reg_rdata[1]) |=> pwr_req);

    a_r10_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[4] |-> !hs_req);

    a_r11_req_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_req) |-> reg_rdata[4]);
endmodule

bind perf_level_ctrl plc_check #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .hs_req    (hs_req),
    .vdom_idx  (vdom_idx),
    .cdom_idx  (cdom_idx),
    .pwr_req   (pwr_req)
);

// File: tb/perf_level_ctrl_tb.sv
`timescale 1ns/1ps
module perf_level_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  sw_lvl = '0;
    logic        boost_trig = 1'b0;
    logic        pwm_state = 1'b0;
    logic        hs_ack = 1'b0;
    logic        hs_req;
    logic [2:0]  vdom_idx;
    logic [2:0]  cdom_idx;
    logic        pwr_req;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] mirror = 8'hE0;
    logic [39:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    perf_level_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sw_lvl(sw_lvl), .boost_trig(boost_trig),
        .pwm_state(pwm_state), .hs_ack(hs_ack), .hs_req(hs_req),
        .vdom_idx(vdom_idx), .cdom_idx(cdom_idx), .pwr_req(pwr_req)
    );

    function automatic logic [7:0] model(input logic [7:0] c, input logic hboost);
        logic       en, pwm_en, ovr, dbg, sync;
        logic [2:0] sel, v;
        logic       boost;
        en = c[0]; pwm_en = c[1]; ovr = c[2]; dbg = c[3]; sync = c[4];
        boost = sync ? hboost : (ovr && boost_trig);
        if (!en)          sel = 3'd7;
        else if (boost)   sel = c[7:5];
        else if (pwm_en)  sel = pwm_state ? 3'd7 : 3'd0;
        else              sel = sw_lvl;
        v = (en && dbg) ? 3'd7 : sel;
        return {1'b0, v, sel, en && pwm_en};
    endfunction

    task automatic push(input logic [7:0] c, input logic hboost, input logic hreq,
                        input logic [7:0] rd, input string tag);
        logic [7:0] m;
        m = model(c, hboost);
        exp_q.push_back({24'h0, rd, m[6:0], (c[4] ? hreq : 1'b0)});
        tag_q.push_back(tag);
    endtask

    task automatic step(input logic [2:0] sw, input logic trig, input logic pwm,
                        input logic ack, input logic hboost, input logic hreq,
                        input string tag);
        @(negedge clk);
        reg_we = 1'b0;
        sw_lvl = sw; boost_trig = trig; pwm_state = pwm; hs_ack = ack;
        push(mirror, hboost, hreq, mirror, tag);
    endtask

    task automatic wr(input logic [31:0] d, input string tag);
        logic [7:0] old;
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = d;
        old = mirror;
        mirror = d[7:0];
        push(old, 1'b0, 1'b0, mirror, tag);
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pop one expected item per edge and compare.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [39:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, "rdata", reg_rdata, e[39:8]);
                chk(t, "vdom",  vdom_idx,  e[7:5]);
                chk(t, "cdom",  cdom_idx,  e[4:2]);
                chk(t, "pwr",   pwr_req,   e[1]);
                chk(t, "hsreq", hs_req,    e[0]);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "rdata", reg_rdata, 32'hE0);
        chk("R1", "vdom", vdom_idx, 7);
        chk("R1", "cdom", cdom_idx, 7);
        chk("R1", "pwr", pwr_req, 0);
        chk("R1", "hsreq", hs_req, 0);
        rst_n = 1'b1;

        step(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 disabled sw3");
        wr(32'hFFFF_FF01, "R3 reserved ignored R2");
        step(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 sw3");
        step(3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R13 sw5");
        step(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 sw0");

        wr(32'h0000_0003, "R2 pwm mode");
        step(3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 pwm high");
        step(3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 pwm low");

        wr(32'h0000_00A7, "R2 boost5 pwm");
        step(3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 boost over pwm");
        step(3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 boost off");

        wr(32'h0000_0065, "R2 boost3");
        step(3'd6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 low boost");
        wr(32'h0000_006D, "R2 debug");
        step(3'd6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7 debug boost");
        step(3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 debug sw2");

        wr(32'h0000_0065, "R2 no debug");
        step(3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R10 ack ignored");
        step(3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R10 direct exit");
        step(3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 idle");

        wr(32'h0000_00B5, "R2 sync boost5");
        step(3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R11 ask");
        step(3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R11 wait ack");
        step(3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R11 ack seen");
        step(3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R11 boosted");
        step(3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R12 req drop");
        step(3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R12 hold on ack");
        step(3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R12 ack low");
        step(3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R12 reverted");

        wr(32'h0000_00E6, "R2 enable off");
        step(3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4 off with bits");
        step(3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4 off pwm");

        @(negedge clk);
        reg_we = 1'b0;
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule